// File: doc/BRIEF.md
# Polled Console Character Peripheral

This block puts a character console on the processor's load/store bus. It holds two independent sides: a receive side that takes characters from a keyboard-style byte source, and a transmit side that hands characters to a display-style byte sink. Each side has one control word and one data word inside a small address window. Software can poll the Ready flags, or it can set a per-side interrupt-enable flag and wait for the matching interrupt line.

The bus port is a single-beat word slave. A read returns its data combinationally in the same cycle as the request, and any side effect of the read takes hold at the next clock edge. Writes take effect at the next clock edge. The bus never stalls, and addresses outside the four registers read as zero. The receive source offers one byte per cycle on a valid strobe, and the peripheral always accepts it. The transmit sink sees a valid/data pair that stays up until the sink drops its busy flag.

Top module: `console_mmio`

## Requirements
- R1: After synchronous active-low reset, the receive control word reads 0, the transmit control word reads 0x1 (Ready set, enable clear), both interrupt lines are low and tx_valid is low.
- R2: A cycle with rx_valid high stores rx_data and sets receive Ready (control bit 0) from the next cycle. The receive data word (offset 0x4) returns the stored character in bits 7:0, with bits 31:8 reading zero.
- R3: A read of the receive data word clears receive Ready from the next cycle. If a character arrives in the same cycle as that read, the read returns the old character and Ready stays set with the new character.
- R4: A character that arrives while receive Ready is set, with no data read in that cycle, replaces the stored character and sets a sticky overrun flag at receive control bit 2. A read of the receive control word clears the flag from the next cycle, unless a new overrun occurs in that same cycle.
- R5: A write to the transmit data word (offset 0xC) with byte-enable bit 0 set, made while transmit Ready is 1, raises tx_valid with wdata[7:0] on tx_data from the next cycle and clears transmit Ready (control bit 0). A write with byte-enable bit 0 clear has no effect.
- R6: tx_valid and tx_data hold while tx_busy is high. After a cycle in which tx_valid is high and tx_busy is low, tx_valid falls and transmit Ready returns to 1.
- R7: A write to the transmit data word while transmit Ready is 0 is ignored: tx_data keeps the pending character and no extra character is sent.
- R8: Control bit 1 of each side is a writable interrupt enable, written from wdata[1] when byte-enable bit 0 is set. irq_rx is high exactly when the receive enable and receive Ready are both 1, and irq_tx is high exactly when the transmit enable and transmit Ready are both 1.
- R9: Reads of any address other than the base (0xFFFF0000) plus 0x0, 0x4 or 0x8, including misaligned ones, return zero, and the transmit data word also reads zero. Writes outside the four registers change nothing.
- R10: Control bits other than Ready (bit 0), enable (bit 1) and receive overrun (bit 2) read as zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 for a store, 0 for a load |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_be | input | 4 | Store byte enables |
| bus_rdata | output | 32 | Load data, valid in the request cycle |
| rx_valid | input | 1 | Incoming character strobe |
| rx_data | input | 8 | Incoming character |
| tx_valid | output | 1 | Outgoing character pending |
| tx_data | output | 8 | Outgoing character |
| tx_busy | input | 1 | Sink not ready to take the character |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The receive path is tried with single characters, back-to-back arrivals that overrun, and an arrival in the same cycle as a data read. Together these separate the set-wins-over-clear ordering from a lost character. The transmit path is tried with a sink that stays busy while a second store arrives, and then with a sink that releases. This tells an ignored store apart from one that overwrites the pending character. A long mixed phase of random accesses, arrivals and busy patterns, including addresses just outside the window, is compared every cycle against a behavioural model of both sides and their interrupt gating.

// File: rtl/console_pkg.sv
// Shared constants and types for the console peripheral.
// Assumes a four-word register window: the word index selects the register.
package console_pkg;
    localparam int RDY_BIT = 0;
    localparam int IE_BIT  = 1;
    localparam int OVR_BIT = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_CTRL,
        SEL_RX_DATA,
        SEL_TX_CTRL,
        SEL_TX_DATA
    } reg_sel_e;

    // Word index inside the window to register slot; the order is fixed by the address map.
    function automatic reg_sel_e slot_of(input logic [1:0] idx);
        case (idx)
            2'd0:    return SEL_RX_CTRL;
            2'd1:    return SEL_RX_DATA;
            2'd2:    return SEL_TX_CTRL;
            default: return SEL_TX_DATA;
        endcase
    endfunction
endpackage

// File: rtl/console_bus_decode.sv
// Address decode and read-data mux for the console register window.
// Assumes word-aligned single-beat accesses; anything else reads zero and
// produces no strobe. Read data is combinational in the request cycle.
module console_bus_decode
    import console_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_be0,
    input  logic              rx_ready,
    input  logic              rx_ie,
    input  logic              rx_ovr,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              tx_ready,
    input  logic              tx_ie,
    output reg_sel_e          rd_sel,
    output reg_sel_e          wr_sel,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int WIN_LSB = 4;

    logic     in_window;
    reg_sel_e hit_sel;

    // Match the upper address bits against the base and require word alignment.
    always_comb begin
        in_window = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
                    && (bus_addr[1:0] == 2'b00);
        hit_sel   = in_window ? slot_of(bus_addr[3:2]) : SEL_NONE;
    end

    // Split the hit into read and write strobes; stores need byte lane 0.
    always_comb begin
        rd_sel = (bus_valid && !bus_write) ? hit_sel : SEL_NONE;
        wr_sel = (bus_valid && bus_write && bus_be0) ? hit_sel : SEL_NONE;
    end

    // Assemble the read word for the selected register.
    always_comb begin
        bus_rdata = '0;
        case (rd_sel)
            SEL_RX_CTRL: begin
                bus_rdata[RDY_BIT] = rx_ready;
                bus_rdata[IE_BIT]  = rx_ie;
                bus_rdata[OVR_BIT] = rx_ovr;
            end
            SEL_RX_DATA: bus_rdata[CHAR_W-1:0] = rx_char;
            SEL_TX_CTRL: begin
                bus_rdata[RDY_BIT] = tx_ready;
                bus_rdata[IE_BIT]  = tx_ie;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/console_rx_side.sv
// Receive side: latches incoming characters, tracks Ready and overrun, and
// gates Ready onto the receive interrupt. Assumes the source is always accepted.
module console_rx_side #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              rd_data_stb,
    input  logic              rd_ctrl_stb,
    input  logic              wr_ctrl_stb,
    input  logic              wr_ie,
    output logic              ready,
    output logic              ie,
    output logic              ovr,
    output logic [CHAR_W-1:0] char_q,
    output logic              irq
);
    logic overrun_now;

    // An arrival overruns when an unread character is held and not read now.
    assign overrun_now = in_valid && ready && !rd_data_stb;

    // Character holding register and Ready flag; arrival wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= 1'b0;
            char_q <= '0;
        end else if (in_valid) begin
            ready  <= 1'b1;
            char_q <= in_char;
        end else if (rd_data_stb) begin
            ready  <= 1'b0;
        end
    end

    // Sticky overrun flag, cleared by a control read unless set again.
    always_ff @(posedge clk) begin
        if (!rst_n)           ovr <= 1'b0;
        else if (overrun_now) ovr <= 1'b1;
        else if (rd_ctrl_stb) ovr <= 1'b0;
    end

    // Software-written interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)           ie <= 1'b0;
        else if (wr_ctrl_stb) ie <= wr_ie;
    end

    assign irq = ie && ready;
endmodule

// File: rtl/console_tx_side.sv
// Transmit side: takes one character from the bus, presents it to the sink
// until the sink is not busy, and gates Ready onto the transmit interrupt.
// Assumes the sink takes a character in any cycle with valid high and busy low.
module console_tx_side #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_stb,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              wr_ctrl_stb,
    input  logic              wr_ie,
    input  logic              out_busy,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    output logic              ready,
    output logic              ie,
    output logic              irq
);
    // Ready is the absence of a pending character.
    assign ready = !out_valid;

    // Pending character register: load when free, release on handoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_char  <= '0;
        end else if (out_valid) begin
            if (!out_busy) out_valid <= 1'b0;
        end else if (wr_data_stb) begin
            out_valid <= 1'b1;
            out_char  <= wr_char;
        end
    end

    // Software-written interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)           ie <= 1'b0;
        else if (wr_ctrl_stb) ie <= wr_ie;
    end

    assign irq = ie && ready;
endmodule

// File: rtl/console_mmio.sv
// Console peripheral top: bus decode plus one receive and one transmit side.
// Assumes a synchronous active-low reset and a never-stalling word bus.
module console_mmio
    import console_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_busy,
    output logic              irq_rx,
    output logic              irq_tx
);
    reg_sel_e          rd_sel, wr_sel;
    logic              rx_ready_w, rx_ie_w, rx_ovr_w, tx_ready_w, tx_ie_w;
    logic [CHAR_W-1:0] rx_char_w;
    logic              unused_bits;

    // Store bits and lanes the registers never look at.
    assign unused_bits = ^{bus_wdata[DATA_W-1:CHAR_W], bus_be[3:1]};

    console_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be0(bus_be[0]),
        .rx_ready(rx_ready_w), .rx_ie(rx_ie_w), .rx_ovr(rx_ovr_w), .rx_char(rx_char_w),
        .tx_ready(tx_ready_w), .tx_ie(tx_ie_w),
        .rd_sel(rd_sel), .wr_sel(wr_sel), .bus_rdata(bus_rdata)
    );

    console_rx_side #(.CHAR_W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_char(rx_data),
        .rd_data_stb(rd_sel == SEL_RX_DATA),
        .rd_ctrl_stb(rd_sel == SEL_RX_CTRL),
        .wr_ctrl_stb(wr_sel == SEL_RX_CTRL),
        .wr_ie(bus_wdata[IE_BIT]),
        .ready(rx_ready_w), .ie(rx_ie_w), .ovr(rx_ovr_w), .char_q(rx_char_w),
        .irq(irq_rx)
    );

    console_tx_side #(.CHAR_W(CHAR_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_data_stb(wr_sel == SEL_TX_DATA),
        .wr_char(bus_wdata[CHAR_W-1:0]),
        .wr_ctrl_stb(wr_sel == SEL_TX_CTRL),
        .wr_ie(bus_wdata[IE_BIT]),
        .out_busy(tx_busy), .out_valid(tx_valid), .out_char(tx_data),
        .ready(tx_ready_w), .ie(tx_ie_w), .irq(irq_tx)
    );
endmodule

// File: rtl/console_mmio_chk.sv
// Property checker for console_mmio, attached by bind below.
// Assumes the same parameters as the top it watches.
module console_mmio_chk #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [3:0]        bus_be,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              tx_busy,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              rx_rdy,
    input logic              tx_rdy
);
    logic is_rxc, is_rxd, is_txc, is_txd, rd_rxd, wr_txd_ok, outside_rd;
    logic unused_chk;

    assign unused_chk = ^{bus_wdata[DATA_W-1:CHAR_W], bus_be[3:1]};

    // Independent address classification for the properties.
    always_comb begin
        is_rxc     = (bus_addr == BASE_ADDR);
        is_rxd     = (bus_addr == BASE_ADDR + 'h4);
        is_txc     = (bus_addr == BASE_ADDR + 'h8);
        is_txd     = (bus_addr == BASE_ADDR + 'hC);
        rd_rxd     = bus_valid && !bus_write && is_rxd;
        wr_txd_ok  = bus_valid && bus_write && is_txd && bus_be[0] && tx_rdy;
        outside_rd = bus_valid && !bus_write && !(is_rxc || is_rxd || is_txc);
    end

    assert_rx_arrival_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_rdy);

    assert_rx_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && !rx_valid) |=> !rx_rdy);

    assert_tx_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd_ok |=> (tx_valid && tx_data == $past(bus_wdata[CHAR_W-1:0])));

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_busy) |=> (tx_valid && $stable(tx_data)));

    assert_tx_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_busy && bus_valid && bus_write && is_txd) |=> $stable(tx_data));

    assert_irq_rx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_rdy);

    assert_irq_tx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> tx_rdy);

    assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        outside_rd |-> (bus_rdata == '0));
endmodule

bind console_mmio console_mmio_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_data(tx_data), .tx_busy(tx_busy),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .rx_rdy(rx_ready_w), .tx_rdy(tx_ready_w)
);

// File: tb/console_mmio_bench.sv
`timescale 1ns/1ps
module console_mmio_bench;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_busy = 1'b0;
    logic        irq_rx, irq_tx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] rd_last;

    // Behavioural reference state
    int m_rx_rdy, m_rx_ie, m_ovr, m_rx_chr, m_txv, m_txd, m_tx_ie;

    always #2 clk = ~clk;

    console_mmio u_console_mmio (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_busy(tx_busy), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] a);
        if (a == BASE)            return 32'(m_ovr*4 + m_rx_ie*2 + m_rx_rdy);
        else if (a == BASE + 4)   return 32'(m_rx_chr);
        else if (a == BASE + 8)   return 32'(m_tx_ie*2 + (m_txv ? 0 : 1));
        else                      return 32'h0;
    endfunction

    function automatic string tag_of(input logic [31:0] a);
        if (a == BASE + 4)                 return "R2";
        else if (a == BASE || a == BASE+8) return "R10";
        else                               return "R9";
    endfunction

    // One bus cycle: drive at the falling edge, compare against the model, then advance it.
    task automatic step(input bit v, input bit w, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input bit rv, input logic [7:0] rc, input bit busy);
        bit rd_d, rd_c, ovr_set;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = wd; bus_be = be;
        rx_valid = rv; rx_data = rc; tx_busy = busy;
        #1;
        chk({31'b0, tx_valid}, 32'(m_txv), "R6");
        if (m_txv != 0) chk({24'b0, tx_data}, 32'(m_txd), "R5");
        chk({31'b0, irq_rx}, 32'(m_rx_ie & m_rx_rdy), "R8");
        chk({31'b0, irq_tx}, 32'(m_tx_ie & (m_txv ? 0 : 1)), "R8");
        if (v && !w) begin
            chk(bus_rdata, model_read(a), tag_of(a));
            rd_last = bus_rdata;
        end
        @(posedge clk);
        rd_d = v && !w && (a == BASE + 4);
        rd_c = v && !w && (a == BASE);
        ovr_set = rv && (m_rx_rdy != 0) && !rd_d;
        if (ovr_set) m_ovr = 1; else if (rd_c) m_ovr = 0;
        if (rv) begin m_rx_rdy = 1; m_rx_chr = rc; end
        else if (rd_d) m_rx_rdy = 0;
        if (v && w && be[0] && a == BASE)     m_rx_ie = wd[1];
        if (v && w && be[0] && a == BASE + 8) m_tx_ie = wd[1];
        if (m_txv != 0) begin
            if (!busy) m_txv = 0;
        end else if (v && w && be[0] && a == BASE + 12) begin
            m_txv = 1; m_txd = wd[7:0];
        end
    endtask

    task automatic rd(input logic [31:0] a, input bit busy);
        step(1, 0, a, 0, 0, 0, 0, busy);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input bit busy);
        step(1, 1, a, d, be, 0, 0, busy);
    endtask

    initial begin
        m_rx_rdy = 0; m_rx_ie = 0; m_ovr = 0; m_rx_chr = 0; m_txv = 0; m_txd = 0; m_tx_ie = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        #1;
        chk({30'b0, irq_rx, irq_tx}, 32'h0, "R1");
        chk({31'b0, tx_valid}, 32'h0, "R1");
        rd(BASE, 0);     chk(rd_last, 32'h0, "R1");
        rd(BASE + 8, 0); chk(rd_last, 32'h1, "R1");

        // R2: a character arrives and is read back in the low byte
        step(0, 0, 0, 0, 0, 1, 8'h41, 0);
        rd(BASE, 0);     chk(rd_last, 32'h1, "R2");
        rd(BASE + 4, 0); chk(rd_last, 32'h41, "R2");

        // R3: the data read cleared Ready; arrival during a read keeps Ready
        rd(BASE, 0);     chk(rd_last, 32'h0, "R3");
        step(0, 0, 0, 0, 0, 1, 8'h42, 0);
        step(1, 0, BASE + 4, 0, 0, 1, 8'h43, 0); chk(rd_last, 32'h42, "R3");
        rd(BASE, 0);     chk(rd_last, 32'h1, "R3");
        rd(BASE + 4, 0); chk(rd_last, 32'h43, "R3");

        // R4: overrun keeps the newest character and is cleared by a control read
        step(0, 0, 0, 0, 0, 1, 8'h01, 0);
        step(0, 0, 0, 0, 0, 1, 8'h02, 0);
        rd(BASE, 0);     chk(rd_last, 32'h5, "R4");
        rd(BASE, 0);     chk(rd_last, 32'h1, "R4");
        rd(BASE + 4, 0); chk(rd_last, 32'h02, "R4");

        // R8: enables gate Ready onto the interrupt lines
        wr(BASE, 32'h2, 4'h1, 0);
        rd(BASE, 0);     chk(rd_last, 32'h2, "R8");
        step(0, 0, 0, 0, 0, 1, 8'h09, 0);
        #1 chk({31'b0, irq_rx}, 32'h1, "R8");
        rd(BASE + 4, 0);
        #1 chk({31'b0, irq_rx}, 32'h0, "R8");
        wr(BASE + 8, 32'h2, 4'h1, 0);
        #1 chk({31'b0, irq_tx}, 32'h1, "R8");

        // R5: a store without lane 0 is dropped; a proper store launches a character
        wr(BASE + 12, 32'h77, 4'h2, 1);
        #1 chk({31'b0, tx_valid}, 32'h0, "R5");
        wr(BASE + 12, 32'h5A, 4'h1, 1);
        #1 chk({23'b0, tx_valid, tx_data}, 32'h15A, "R5");
        rd(BASE + 8, 1); chk(rd_last, 32'h2, "R5");

        // R7: store while busy is ignored
        wr(BASE + 12, 32'h33, 4'h1, 1);
        #1 chk({24'b0, tx_data}, 32'h5A, "R7");

        // R6: hold while busy, then hand off
        step(0, 0, 0, 0, 0, 0, 0, 1);
        #1 chk({31'b0, tx_valid}, 32'h1, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0);
        #1 chk({31'b0, tx_valid}, 32'h0, "R6");
        rd(BASE + 8, 0); chk(rd_last, 32'h3, "R6");

        // R9: out-of-window and misaligned reads, and a stray store
        rd(BASE + 16, 0); chk(rd_last, 32'h0, "R9");
        rd(32'h0, 0);     chk(rd_last, 32'h0, "R9");
        rd(BASE + 2, 0);  chk(rd_last, 32'h0, "R9");
        rd(BASE + 12, 0); chk(rd_last, 32'h0, "R9");
        wr(BASE + 20, 32'hFFFF_FFFF, 4'hF, 0);
        rd(BASE + 8, 0);  chk(rd_last, 32'h3, "R9");

        // R10: writing all ones only sets the enable bit
        wr(BASE, 32'hFFFF_FFFF, 4'hF, 0);
        rd(BASE, 0);      chk(rd_last & 32'hFFFF_FFF8, 32'h0, "R10");
        wr(BASE + 8, 32'hFFFF_FFFD, 4'hF, 0);
        rd(BASE + 8, 0);  chk(rd_last, 32'h1, "R10");

        // Mixed phase compared every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            case ($urandom_range(0, 6))
                0: a = BASE;       1: a = BASE + 4;  2: a = BASE + 8;
                3: a = BASE + 12;  4: a = BASE + 16; 5: a = BASE - 4;
                default: a = BASE + 4;
            endcase
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, $urandom(),
                 4'($urandom_range(0, 15)), $urandom_range(0, 3) == 0,
                 8'($urandom_range(0, 255)), $urandom_range(0, 1) == 1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule